// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block lies between a host register file and the engine that drives the card's command line in an SD/MMC-style controller. The host loads an argument word, then writes a command word whose top bit asks for the command to be issued. The block executes one command at a time and keeps one more waiting behind it. A further issue attempt while both places are taken is refused and flagged as a lock error. The card-side engine is represented by a simple handshake. The block pulses an issue strobe, and the engine later reports that the command was sent, that a response arrived (with CRC and response-error flags), or that no response came in time.

On completion the block sets a raw done flag together with the matching error flags, which are cleared by writing ones. A short response lands in word 0 of the response store, and a long one fills all words. The block also holds a clock-divider setting that cannot be changed while any command is in flight. A masked OR of the raw flags drives the interrupt line.

Execution is controlled by a three-state machine:
- S_IDLE waits for work. It moves to S_ISSUE when a command is launched, either freshly written or promoted from the waiting slot.
- S_ISSUE asserts the issue strobe for one cycle and always moves on to S_WAIT.
- S_WAIT returns to S_IDLE on the finish event. For a no-response command the finish event is the sent report. For a short or long command it is a response or a timeout.

Top module: `sdc_cmd_issue`

Register addresses (reg_wr_addr): 0 argument, 1 command, 2 raw status (write 1 to clear), 3 interrupt mask, 4 clock divider. Command word: bits [5:0] command index, bits [7:6] response type (00 none, 01 short, 10 or 11 long), bit 31 start. Raw status bits: 0 done, 1 response timeout, 2 response CRC error, 3 response error, 4 lock error.

## Requirements
- R1: A command write with bit 31 set, made while nothing executes and nothing waits, is launched at once. The next cycle shows eng_issue high for one cycle, with the written index and type and the current argument, and start_flag stays 0.
- R2: A start write made while a command executes is held in the single waiting slot, and start_flag reads 1. One cycle after the executing command completes, the held command is launched: start_flag returns to 0 and eng_issue rises. Commands are issued in write order.
- R3: A start write made while a command executes and another waits sets raw status bit 4 and is discarded, so it is never issued.
- R4: Raw status bit 0 is set in the cycle after a response or a timeout ends a short or long command.
- R5: A valid short response updates only resp_data[31:0] and leaves the other words unchanged. A valid long response replaces all of resp_data: eng_resp_data bit 127 goes to bit 127 (the MSB of word 3) and bit 0 goes to bit 0 (the LSB of word 0).
- R6: A timeout sets status bit 1, a response with a CRC error sets bit 2, and a response with a response error sets bit 3, each together with bit 0. A timeout leaves resp_data unchanged.
- R7: For response type 00, status bit 0 is set once eng_sent is reported, with no response or timeout needed.
- R8: A clock-divider write is ignored while a command executes or waits, and is taken when the block is idle.
- R9: Writing ones to the raw status address clears those bits, and writing zeros has no effect. irq is high exactly when some raw bit is set and its mask bit is 1.
- R10: After reset the raw status, start_flag, irq, eng_issue and resp_data are 0, and clk_div holds CLKDIV_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register address |
| reg_wr_data | input | 32 | Register write data |
| start_flag | output | 1 | Start bit view: 1 while a written command is not yet launched |
| raw_status | output | 5 | Raw status flags |
| irq | output | 1 | Masked interrupt |
| resp_data | output | RESP_WORDS*32 | Response store, word 0 in the low bits |
| clk_div | output | CLKDIV_W | Clock divider setting |
| eng_issue | output | 1 | One-cycle issue strobe to the engine |
| eng_index | output | 6 | Index of the executing command |
| eng_arg | output | 32 | Argument of the executing command |
| eng_rtype | output | 2 | Response type of the executing command |
| eng_sent | input | 1 | Engine: command sent |
| eng_resp_valid | input | 1 | Engine: response received |
| eng_timeout | input | 1 | Engine: response timeout |
| eng_crc_err | input | 1 | Engine: response CRC error, with eng_resp_valid |
| eng_resp_err | input | 1 | Engine: response error, with eng_resp_valid |
| eng_resp_data | input | RESP_WORDS*32 | Engine: response bits |

## Verification
The bench targets the moment a waiting command is promoted. It samples start_flag and eng_issue in the cycle just after completion, because a design that promotes late or too early shifts those edges, and a design that drops the held command never issues it. It fills both slots and then makes a third start attempt. A design that overwrites the waiting slot would issue the wrong argument, and one without the lock check would leave bit 4 clear. It sends a short response after a long one, which catches upper words that are wrongly zeroed, and a timeout, which catches a store that captures garbage. It also writes the clock divider while a command is busy, which exposes a missing write block.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int REG_W   = 32;
    localparam int IDX_W   = 6;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_ARG    = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMD    = 3'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLKDIV = 3'd4;

    localparam int START_BIT = 31;

    localparam int ST_DONE = 0;
    localparam int ST_TOUT = 1;
    localparam int ST_CRC  = 2;
    localparam int ST_RERR = 3;
    localparam int ST_LOCK = 4;
    localparam int ST_W    = 5;

    localparam logic [1:0] RT_NONE  = 2'b00;
    localparam logic [1:0] RT_SHORT = 2'b01;

    typedef struct packed {
        logic [REG_W-1:0] arg;
        logic [IDX_W-1:0] index;
        logic [1:0]       rtype;
    } cmd_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } exec_state_e;

endpackage

// File: rtl/sdc_cmd_regs.sv
module sdc_cmd_regs
    import sdc_pkg::*;
#(
    parameter int CLKDIV_W = 8,
    parameter logic [CLKDIV_W-1:0] CLKDIV_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                busy_any,
    input  logic [ST_W-1:0]     set_vec,
    output logic [REG_W-1:0]    arg_q,
    output logic [CLKDIV_W-1:0] clkdiv_q,
    output logic [ST_W-1:0]     raw_q,
    output logic                irq
);

    logic [ST_W-1:0] mask_q;
    logic [ST_W-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        if (wr_en && wr_addr == A_STATUS) begin
            clr_vec = wr_data[ST_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q    <= '0;
            mask_q   <= '0;
            clkdiv_q <= CLKDIV_RST;
            raw_q    <= '0;
        end else begin
            if (wr_en && wr_addr == A_ARG) begin
                arg_q <= wr_data;
            end
            if (wr_en && wr_addr == A_MASK) begin
                mask_q <= wr_data[ST_W-1:0];
            end
            if (wr_en && wr_addr == A_CLKDIV && !busy_any) begin
                clkdiv_q <= wr_data[CLKDIV_W-1:0];
            end
            raw_q <= (raw_q & ~clr_vec) | set_vec;
        end
    end

    assign irq = |(raw_q & mask_q);

endmodule

// File: rtl/sdc_cmd_queue.sv
module sdc_cmd_queue
    import sdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  cmd_t new_cmd,
    input  logic exec_idle,
    output logic launch,
    output cmd_t launch_cmd,
    output logic buf_valid,
    output logic lock_err
);

    cmd_t buf_cmd;
    logic promote;
    logic accept_now;
    logic take;

    always_comb begin
        promote    = exec_idle && buf_valid;
        accept_now = start_wr && exec_idle && !buf_valid;
        take       = start_wr && !accept_now && (!buf_valid || promote);
        lock_err   = start_wr && buf_valid && !promote;
        launch     = promote || accept_now;
        launch_cmd = promote ? buf_cmd : new_cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            buf_cmd   <= '0;
        end else if (take) begin
            buf_valid <= 1'b1;
            buf_cmd   <= new_cmd;
        end else if (promote) begin
            buf_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sdc_cmd_fsm.sv
module sdc_cmd_fsm
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  cmd_t             launch_cmd,
    input  logic             eng_sent,
    input  logic             eng_resp_valid,
    input  logic             eng_timeout,
    input  logic             eng_crc_err,
    input  logic             eng_resp_err,
    output logic             exec_idle,
    output logic             eng_issue,
    output logic [IDX_W-1:0] eng_index,
    output logic [REG_W-1:0] eng_arg,
    output logic [1:0]       eng_rtype,
    output logic [3:0]       done_set,
    output logic             cap_short,
    output logic             cap_long
);

    exec_state_e state, state_nx;
    cmd_t        cur;
    logic        finish;
    logic        has_resp;

    assign has_resp = (cur.rtype != RT_NONE);
    assign finish   = (state == S_WAIT) &&
                      (has_resp ? (eng_resp_valid || eng_timeout) : eng_sent);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (launch) state_nx = S_ISSUE;
            S_ISSUE: state_nx = S_WAIT;
            S_WAIT:  if (finish) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cur   <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && launch) begin
                cur <= launch_cmd;
            end
        end
    end

    always_comb begin
        exec_idle = 1'b0;
        eng_issue = 1'b0;
        done_set  = '0;
        cap_short = 1'b0;
        cap_long  = 1'b0;
        unique case (state)
            S_IDLE:  exec_idle = 1'b1;
            S_ISSUE: eng_issue = 1'b1;
            S_WAIT: begin
                if (finish) begin
                    done_set[ST_DONE] = 1'b1;
                    if (has_resp) begin
                        done_set[ST_TOUT] = eng_timeout;
                        done_set[ST_CRC]  = eng_resp_valid && eng_crc_err;
                        done_set[ST_RERR] = eng_resp_valid && eng_resp_err;
                        cap_short = eng_resp_valid && !eng_timeout &&
                                    (cur.rtype == RT_SHORT);
                        cap_long  = eng_resp_valid && !eng_timeout &&
                                    cur.rtype[1];
                    end
                end
            end
            default: exec_idle = 1'b0;
        endcase
    end

    assign eng_index = cur.index;
    assign eng_arg   = cur.arg;
    assign eng_rtype = cur.rtype;

endmodule

// File: rtl/sdc_resp_store.sv
module sdc_resp_store
    import sdc_pkg::*;
#(
    parameter int RESP_WORDS = 4,
    localparam int RESP_W = RESP_WORDS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_short,
    input  logic              cap_long,
    input  logic [RESP_W-1:0] din,
    output logic [RESP_W-1:0] dout
);

    for (genvar w = 0; w < RESP_WORDS; w++) begin : g_word
        logic load;
        if (w == 0) begin : g_low
            assign load = cap_short || cap_long;
        end else begin : g_high
            assign load = cap_long;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dout[w*REG_W +: REG_W] <= '0;
            end else if (load) begin
                dout[w*REG_W +: REG_W] <= din[w*REG_W +: REG_W];
            end
        end
    end

endmodule

// File: rtl/sdc_cmd_issue.sv
module sdc_cmd_issue
    import sdc_pkg::*;
#(
    parameter int RESP_WORDS = 4,
    parameter int CLKDIV_W   = 8,
    parameter logic [CLKDIV_W-1:0] CLKDIV_RST = 8'h04,
    localparam int RESP_W = RESP_WORDS * REG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_wr_addr,
    input  logic [REG_W-1:0]    reg_wr_data,
    output logic                start_flag,
    output logic [ST_W-1:0]     raw_status,
    output logic                irq,
    output logic [RESP_W-1:0]   resp_data,
    output logic [CLKDIV_W-1:0] clk_div,
    output logic                eng_issue,
    output logic [IDX_W-1:0]    eng_index,
    output logic [REG_W-1:0]    eng_arg,
    output logic [1:0]          eng_rtype,
    input  logic                eng_sent,
    input  logic                eng_resp_valid,
    input  logic                eng_timeout,
    input  logic                eng_crc_err,
    input  logic                eng_resp_err,
    input  logic [RESP_W-1:0]   eng_resp_data
);

    logic [REG_W-1:0] arg_q;
    logic             start_wr;
    cmd_t             new_cmd;
    logic             launch;
    cmd_t             launch_cmd;
    logic             buf_valid;
    logic             lock_err;
    logic             exec_idle;
    logic             exec_busy;
    logic [3:0]       done_set;
    logic             cap_short;
    logic             cap_long;
    logic [ST_W-1:0]  set_vec;

    assign start_wr = reg_wr_en && (reg_wr_addr == A_CMD) &&
                      reg_wr_data[START_BIT];
    assign new_cmd  = '{arg: arg_q, index: reg_wr_data[IDX_W-1:0],
                        rtype: reg_wr_data[IDX_W+1:IDX_W]};
    assign exec_busy  = !exec_idle;
    assign start_flag = buf_valid;
    assign set_vec    = {lock_err, done_set};

    sdc_cmd_regs #(
        .CLKDIV_W   (CLKDIV_W),
        .CLKDIV_RST (CLKDIV_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .busy_any (exec_busy || buf_valid),
        .set_vec  (set_vec),
        .arg_q    (arg_q),
        .clkdiv_q (clk_div),
        .raw_q    (raw_status),
        .irq      (irq)
    );

    sdc_cmd_queue u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .new_cmd    (new_cmd),
        .exec_idle  (exec_idle),
        .launch     (launch),
        .launch_cmd (launch_cmd),
        .buf_valid  (buf_valid),
        .lock_err   (lock_err)
    );

    sdc_cmd_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch         (launch),
        .launch_cmd     (launch_cmd),
        .eng_sent       (eng_sent),
        .eng_resp_valid (eng_resp_valid),
        .eng_timeout    (eng_timeout),
        .eng_crc_err    (eng_crc_err),
        .eng_resp_err   (eng_resp_err),
        .exec_idle      (exec_idle),
        .eng_issue      (eng_issue),
        .eng_index      (eng_index),
        .eng_arg        (eng_arg),
        .eng_rtype      (eng_rtype),
        .done_set       (done_set),
        .cap_short      (cap_short),
        .cap_long       (cap_long)
    );

    sdc_resp_store #(
        .RESP_WORDS (RESP_WORDS)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_short (cap_short),
        .cap_long  (cap_long),
        .din       (eng_resp_data),
        .dout      (resp_data)
    );

endmodule

// File: rtl/sdc_cmd_issue_chk.sv
module sdc_cmd_issue_chk
    import sdc_pkg::*;
#(
    parameter int RESP_W   = 128,
    parameter int CLKDIV_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr_en,
    input logic [ADDR_W-1:0]   reg_wr_addr,
    input logic [REG_W-1:0]    reg_wr_data,
    input logic                exec_busy,
    input logic                start_flag,
    input logic                eng_issue,
    input logic [1:0]          eng_rtype,
    input logic                eng_resp_valid,
    input logic                eng_timeout,
    input logic [ST_W-1:0]     raw_status,
    input logic [RESP_W-1:0]   resp_data,
    input logic [CLKDIV_W-1:0] clk_div
);

    logic start_wr;
    assign start_wr = reg_wr_en && reg_wr_addr == A_CMD && reg_wr_data[START_BIT];

    assert_launch_now_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr && !exec_busy && !start_flag |=> eng_issue);

    assert_issue_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_issue |=> !eng_issue);

    assert_lock_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr && start_flag && exec_busy |=> raw_status[ST_LOCK]);

    assert_done_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_busy && !eng_issue && eng_rtype != RT_NONE &&
        (eng_resp_valid || eng_timeout) |=> raw_status[ST_DONE]);

    assert_timeout_keeps_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_busy && !eng_issue && eng_timeout |=> $stable(resp_data));

    assert_clkdiv_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_wr_addr == A_CLKDIV && (exec_busy || start_flag)
        |=> $stable(clk_div));

endmodule

bind sdc_cmd_issue sdc_cmd_issue_chk #(
    .RESP_W   (RESP_WORDS * 32),
    .CLKDIV_W (CLKDIV_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_wr_addr    (reg_wr_addr),
    .reg_wr_data    (reg_wr_data),
    .exec_busy      (exec_busy),
    .start_flag     (start_flag),
    .eng_issue      (eng_issue),
    .eng_rtype      (eng_rtype),
    .eng_resp_valid (eng_resp_valid),
    .eng_timeout    (eng_timeout),
    .raw_status     (raw_status),
    .resp_data      (resp_data),
    .clk_div        (clk_div)
);

// File: tb/tb_sdc_cmd_issue.sv
`timescale 1ns/1ps
module tb_sdc_cmd_issue;

    localparam int K_SENT = 0;
    localparam int K_OK   = 1;
    localparam int K_TO   = 2;
    localparam int K_CRC  = 3;
    localparam int K_ERR  = 4;
    localparam int ENG_DELAY = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [2:0]   reg_wr_addr = '0;
    logic [31:0]  reg_wr_data = '0;
    logic         start_flag;
    logic [4:0]   raw_status;
    logic         irq;
    logic [127:0] resp_data;
    logic [7:0]   clk_div;
    logic         eng_issue;
    logic [5:0]   eng_index;
    logic [31:0]  eng_arg;
    logic [1:0]   eng_rtype;
    logic         eng_sent = 1'b0;
    logic         eng_resp_valid = 1'b0;
    logic         eng_timeout = 1'b0;
    logic         eng_crc_err = 1'b0;
    logic         eng_resp_err = 1'b0;
    logic [127:0] eng_resp_data = '0;

    int n_checks = 0;
    int n_errors = 0;
    int n_issued = 0;
    int n_pushed = 0;

    logic [39:0]  exp_q[$];
    int           kind_q[$];
    logic [127:0] data_q[$];

    always #2 clk = ~clk;

    sdc_cmd_issue dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .start_flag(start_flag), .raw_status(raw_status), .irq(irq),
        .resp_data(resp_data), .clk_div(clk_div),
        .eng_issue(eng_issue), .eng_index(eng_index), .eng_arg(eng_arg),
        .eng_rtype(eng_rtype), .eng_sent(eng_sent), .eng_resp_valid(eng_resp_valid),
        .eng_timeout(eng_timeout), .eng_crc_err(eng_crc_err),
        .eng_resp_err(eng_resp_err), .eng_resp_data(eng_resp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // driver: pushes expected issue and the engine's planned answer
    task automatic issue(input logic [5:0] idx, input logic [1:0] rt,
                         input logic [31:0] arg, input int kind,
                         input logic [127:0] data);
        exp_q.push_back({idx, rt, arg});
        kind_q.push_back(kind);
        data_q.push_back(data);
        n_pushed++;
        write_reg(3'd0, arg);
        write_reg(3'd1, {1'b1, 23'd0, rt, idx});
    endtask

    task automatic wait_done();
        while (!raw_status[0]) @(negedge clk);
    endtask

    task automatic clear_all();
        write_reg(3'd2, 32'h1f);
    endtask

    // monitor: scoreboard of issued commands (R1, R2)
    always @(negedge clk) begin
        if (rst_n && eng_issue) begin
            n_issued++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected issue", {88'd0, eng_index, eng_rtype, eng_arg}, '0);
            end else begin
                logic [39:0] e;
                e = exp_q.pop_front();
                check({eng_index, eng_rtype, eng_arg} == e, "R2 issue order/content",
                      {88'd0, eng_index, eng_rtype, eng_arg}, {88'd0, e});
            end
        end
    end

    // engine model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && eng_issue && kind_q.size() != 0) begin
                int k;
                logic [127:0] d;
                k = kind_q.pop_front();
                d = data_q.pop_front();
                repeat (ENG_DELAY) @(negedge clk);
                eng_sent       = 1'b1;
                eng_resp_valid = (k == K_OK) || (k == K_CRC) || (k == K_ERR);
                eng_timeout    = (k == K_TO);
                eng_crc_err    = (k == K_CRC);
                eng_resp_err   = (k == K_ERR);
                eng_resp_data  = d;
                @(negedge clk);
                eng_sent = 1'b0; eng_resp_valid = 1'b0; eng_timeout = 1'b0;
                eng_crc_err = 1'b0; eng_resp_err = 1'b0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    localparam logic [127:0] D1 = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    localparam logic [127:0] D2 = 128'h8123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6979;
    localparam logic [127:0] D3 = 128'hFFFF_0000_FFFF_0000_ABCD_EF01_2345_6789;

    initial begin
        logic [127:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check(raw_status == 5'd0, "R10 raw status", raw_status, 0);
        check(start_flag == 1'b0 && irq == 1'b0 && eng_issue == 1'b0,
              "R10 flags", {start_flag, irq, eng_issue}, 0);
        check(resp_data == '0, "R10 resp", resp_data, 0);
        check(clk_div == 8'h04, "R10 clkdiv", clk_div, 8'h04);

        // R1 / R5 short response
        issue(6'd5, 2'b01, 32'hA1A1_0001, K_OK, D1);
        check(start_flag == 1'b0, "R1 start cleared", start_flag, 0);
        wait_done();
        check(raw_status == 5'b00001, "R4 done short", raw_status, 5'b00001);
        check(resp_data == {96'd0, D1[31:0]}, "R5 short word0 only", resp_data,
              {96'd0, D1[31:0]});
        clear_all();

        // R5 long response
        issue(6'd2, 2'b10, 32'hB2B2_0002, K_OK, D2);
        wait_done();
        check(resp_data == D2, "R5 long all words", resp_data, D2);
        check(resp_data[127] == 1'b1 && resp_data[0] == 1'b1, "R5 msb/lsb map",
              {resp_data[127], resp_data[0]}, 2'b11);
        clear_all();

        // R5 short after long keeps upper words
        issue(6'd13, 2'b01, 32'hC3C3_0003, K_OK, D3);
        wait_done();
        check(resp_data == {D2[127:32], D3[31:0]}, "R5 upper words kept", resp_data,
              {D2[127:32], D3[31:0]});
        clear_all();

        // R6 timeout
        keep = resp_data;
        issue(6'd8, 2'b10, 32'h0000_0008, K_TO, D1);
        wait_done();
        check(raw_status == 5'b00011, "R6 timeout flags", raw_status, 5'b00011);
        check(resp_data == keep, "R6 timeout keeps resp", resp_data, keep);
        clear_all();

        // R6 crc error
        issue(6'd9, 2'b01, 32'h0000_0009, K_CRC, D1);
        wait_done();
        check(raw_status == 5'b00101, "R6 crc flags", raw_status, 5'b00101);
        clear_all();

        // R6 response error
        issue(6'd10, 2'b01, 32'h0000_000A, K_ERR, D1);
        wait_done();
        check(raw_status == 5'b01001, "R6 resp err flags", raw_status, 5'b01001);
        clear_all();

        // R7 no response
        keep = resp_data;
        issue(6'd0, 2'b00, 32'h0000_0000, K_SENT, D3);
        wait_done();
        check(raw_status == 5'b00001, "R7 done on sent", raw_status, 5'b00001);
        check(resp_data == keep, "R7 resp untouched", resp_data, keep);

        // R9 mask / W1C
        check(irq == 1'b0, "R9 masked irq low", irq, 0);
        write_reg(3'd3, 32'h1);
        check(irq == 1'b1, "R9 irq enabled", irq, 1);
        write_reg(3'd2, 32'h0);
        check(raw_status == 5'b00001, "R9 zero write no effect", raw_status, 5'b00001);
        write_reg(3'd2, 32'h1);
        check(raw_status == 5'b00000 && irq == 1'b0, "R9 W1C clear",
              {raw_status, irq}, 0);
        write_reg(3'd3, 32'h0);

        // R2 buffering and promotion
        issue(6'd17, 2'b10, 32'hAAAA_0017, K_OK, D1);
        issue(6'd18, 2'b01, 32'hBBBB_0018, K_OK, D2);
        check(start_flag == 1'b1, "R2 start held", start_flag, 1);
        wait_done();
        check(start_flag == 1'b1 && eng_issue == 1'b0, "R2 not yet promoted",
              {start_flag, eng_issue}, 2'b10);
        @(negedge clk);
        check(start_flag == 1'b0 && eng_issue == 1'b1, "R2 promoted next cycle",
              {start_flag, eng_issue}, 2'b01);
        clear_all();
        wait_done();
        check(resp_data[31:0] == D2[31:0], "R2 second resp", resp_data[31:0], D2[31:0]);
        clear_all();

        // R3 lock error on third start
        issue(6'd20, 2'b01, 32'h0000_0020, K_OK, D1);
        issue(6'd21, 2'b01, 32'h0000_0021, K_OK, D2);
        write_reg(3'd0, 32'hDEAD_0022);
        write_reg(3'd1, {1'b1, 23'd0, 2'b01, 6'd22});
        check(raw_status[4] == 1'b1, "R3 lock flag", raw_status, 5'b10000);
        check(start_flag == 1'b1, "R3 buffer kept", start_flag, 1);
        wait_done();
        clear_all();
        wait_done();
        clear_all();
        repeat (20) @(negedge clk);
        check(n_issued == n_pushed, "R3 third not issued", n_issued, n_pushed);

        // R8 clock divider blocked while busy
        issue(6'd30, 2'b10, 32'h0000_0030, K_OK, D3);
        write_reg(3'd4, 32'hAB);
        check(clk_div == 8'h04, "R8 blocked while busy", clk_div, 8'h04);
        wait_done();
        clear_all();
        write_reg(3'd4, 32'h3C);
        check(clk_div == 8'h3C, "R8 taken when idle", clk_div, 8'h3C);

        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        report();
    end

endmodule